// File: doc/BRIEF.md
# Latched Protection Fault Manager for a Flash LED Driver

This block gathers the protection events of a camera flash LED driver into one sticky fault status byte. It covers overvoltage at the boost output, overtemperature, a flash watchdog timeout and a shorted LED cathode. While any bit of that byte is set, the block requests the interrupt line low through an open-drain output enable and holds the LED driver off. Faults persist after their cause goes away. Software clears them with a clear strobe in register mode; in two-pin logic mode, driving both control pins low clears them. Dropping the chip enable or raising the undervoltage lockout wipes every fault.

Two timed detectors are built in. The first is a short-circuit check. It samples the synchronized "cathode grounded" comparator flag once, a fixed hold time after the torch is switched on. Any change of the torch level, including switching it off, restarts that hold time, so a level change near the end of the window can never produce a false measurement. The second is the two-pin mode flash watchdog. It raises the timeout fault when both control pins stay high for the hold time. The comparator flags are level inputs that each pass through a synchronizer. All control and status signals are plain levels; there is no streaming interface.

Top module: `led_fault_guard`

## Requirements
- R1: The status byte maps overvoltage to bit 0, watchdog timeout to bit 1, overtemperature to bit 2 and short-circuit to bit 3. Bits 7..4 always read 0. After reset the byte is 0x00.
- R2: A raw overvoltage, overtemperature or timeout-event input passes through SYNC_STAGES (default 2) flops. If it is driven high before rising edge e, its bit is set after edge e+SYNC_STAGES and not before. The bit stays set after the input returns low.
- R3: `irq_oe` and `drv_off` are 1 exactly when at least one fault bit is 1.
- R4: In register mode (`pin_mode`=0), a one-cycle `clr_strobe` clears all fault bits and releases `irq_oe`. The control pins have no clearing effect in this mode.
- R5: In two-pin logic mode (`pin_mode`=1), any cycle with both `ctl_hi` and `ctl_lo` low clears all fault bits. `clr_strobe` has no effect in this mode.
- R6: A fault whose synchronized input is asserted in the same cycle as a clear ends up set after that edge. All other bits are cleared.
- R7: While `chip_en` is 0 or `uvlo` is 1, every fault bit reads 0 on the following edge and stays 0, whatever the fault inputs do. `irq_oe` is then 0.
- R8: After `torch_lvl` changes to a non-zero value, bit 3 is set exactly HOLD_CYCLES edges after the first edge that samples the new level. This happens only if the synchronized cathode flag is 1 at that moment. The check runs once per level, so grounding that appears later sets nothing.
- R9: Changing `torch_lvl` to a different non-zero value, or to 0 and back, restarts the short-circuit hold time from the edge that samples the change.
- R10: In two-pin mode, bit 1 is set on the HOLD_CYCLES-th consecutive edge that samples both control pins high. Leaving that state earlier sets nothing.
- R11: A pulse on `wdt_evt_raw` (the timeout of the register-mode strobe timer) sets bit 1 with the latency given in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable; low wipes all faults |
| uvlo | input | 1 | Undervoltage lockout; high wipes all faults |
| pin_mode | input | 1 | 1 = two-pin logic mode, 0 = register mode |
| ctl_hi | input | 1 | Upper control pin (two-pin mode) |
| ctl_lo | input | 1 | Lower control pin (two-pin mode) |
| clr_strobe | input | 1 | Clear pulse from a zero write to the output select register |
| ovp_raw | input | 1 | Output overvoltage comparator flag |
| otp_raw | input | 1 | Overtemperature flag |
| wdt_evt_raw | input | 1 | Strobe timer timeout event |
| cath_gnd_raw | input | 1 | LED cathode grounded comparator flag |
| torch_lvl | input | LVL_W | Torch current code; non-zero means torch on |
| fault_byte | output | 8 | Fault status byte |
| irq_oe | output | 1 | Open-drain pull-down enable for the interrupt line |
| drv_off | output | 1 | Disables the LED driver while a fault is latched |

## Verification
The collision that matters is a clear and a newly arriving fault in the same cycle. The bench provokes it by latching one fault and then timing a second raw input so that its synchronized level reaches the fault register exactly on the edge where `clr_strobe` is high. The result must show only the newly arriving bit. A second case of this kind is a torch level change landing just before the short-circuit check would fire. The bench judges it by checking that the bit stays clear for a full hold time after the change and sets on exactly the following edge.

// File: rtl/lfg_pkg.sv
package lfg_pkg;
  localparam int FB_OV  = 0;
  localparam int FB_WD  = 1;
  localparam int FB_OT  = 2;
  localparam int FB_SC  = 3;
  localparam int NFLT   = 4;
  localparam int BYTE_W = 8;
  typedef logic [NFLT-1:0] flt_vec_t;
endpackage

// File: rtl/lfg_sync.sv
module lfg_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= '0;
        else if (g == 0) st[g] <= d;
        else st[g] <= st[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/lfg_hold_timer.sv
module lfg_hold_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);

  logic [CW-1:0] cnt;

  // one pulse per run: counter parks at TOP after the check
  assign expire = run && !restart && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!run || restart) cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lfg_fault_reg.sv
module lfg_fault_reg
  import lfg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wipe,
  input  logic     clear,
  input  flt_vec_t set_vec,
  output flt_vec_t flt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flt <= '0;
    else if (wipe) flt <= '0;
    else flt <= (clear ? '0 : flt) | set_vec;  // a new event outlives a clear
  end
endmodule

// File: rtl/led_fault_guard.sv
module led_fault_guard
  import lfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 1000,
  parameter int LVL_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en,
  input  logic             uvlo,
  input  logic             pin_mode,
  input  logic             ctl_hi,
  input  logic             ctl_lo,
  input  logic             clr_strobe,
  input  logic             ovp_raw,
  input  logic             otp_raw,
  input  logic             wdt_evt_raw,
  input  logic             cath_gnd_raw,
  input  logic [LVL_W-1:0] torch_lvl,
  output logic [7:0]       fault_byte,
  output logic             irq_oe,
  output logic             drv_off
);
  flt_vec_t raw_vec, sync_q, set_vec, flt;
  logic en_ok, clear_act, cath_s;
  logic [LVL_W-1:0] prev_lvl;
  logic sc_run, sc_restart, sc_exp, fl_run, fl_exp;

  assign en_ok = chip_en && !uvlo;

  always_comb begin
    raw_vec        = '0;
    raw_vec[FB_OV] = ovp_raw;
    raw_vec[FB_WD] = wdt_evt_raw;
    raw_vec[FB_OT] = otp_raw;
    raw_vec[FB_SC] = cath_gnd_raw;
  end

  lfg_sync #(.W(NFLT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_vec), .q(sync_q)
  );

  assign cath_s = sync_q[FB_SC];

  // short-circuit check: one sample per stable non-zero torch level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_lvl <= '0;
    else prev_lvl <= torch_lvl;
  end

  assign sc_run     = en_ok && (torch_lvl != '0);
  assign sc_restart = (torch_lvl != prev_lvl);

  lfg_hold_timer #(.LIMIT(HOLD_CYCLES)) u_sc_tmr (
    .clk(clk), .rst_n(rst_n), .run(sc_run), .restart(sc_restart), .expire(sc_exp)
  );

  // two-pin flash watchdog
  assign fl_run = en_ok && pin_mode && ctl_hi && ctl_lo;

  lfg_hold_timer #(.LIMIT(HOLD_CYCLES)) u_fl_tmr (
    .clk(clk), .rst_n(rst_n), .run(fl_run), .restart(1'b0), .expire(fl_exp)
  );

  always_comb begin
    set_vec        = '0;
    set_vec[FB_OV] = sync_q[FB_OV];
    set_vec[FB_OT] = sync_q[FB_OT];
    set_vec[FB_WD] = sync_q[FB_WD] | fl_exp;
    set_vec[FB_SC] = sc_exp & cath_s;
  end

  assign clear_act = pin_mode ? (!ctl_hi && !ctl_lo) : clr_strobe;

  lfg_fault_reg u_freg (
    .clk(clk), .rst_n(rst_n), .wipe(!en_ok), .clear(clear_act),
    .set_vec(set_vec), .flt(flt)
  );

  assign fault_byte = {{(BYTE_W-NFLT){1'b0}}, flt};
  assign irq_oe     = |flt;
  assign drv_off    = |flt;
endmodule

// File: rtl/lfg_chk.sv
module lfg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_ok,
  input logic       clear,
  input logic [3:0] set_vec,
  input logic       cath_s,
  input logic [3:0] flt,
  input logic       irq_oe
);
  // R7
  wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_ok |=> (flt == 4'h0) && !irq_oe);

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_ok && clear && set_vec == 4'h0) |=> flt == 4'h0);

  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_ok && !clear) |=> ((flt & $past(flt)) == $past(flt)));

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_ok && set_vec != 4'h0) |=> ((flt & $past(set_vec)) == $past(set_vec)));

  // R3
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_oe) |-> $past(set_vec) != 4'h0);

  // R8
  scp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt[3]) |-> $past(cath_s));
endmodule

bind led_fault_guard lfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_ok(en_ok), .clear(clear_act),
  .set_vec(set_vec), .cath_s(cath_s), .flt(flt), .irq_oe(irq_oe)
);

// File: tb/sim_led_fault_guard.sv
module sim_led_fault_guard;
  localparam int HOLD = 1000;
  localparam int LW   = 5;

  logic clk = 1'b0;
  logic rst_n, chip_en, uvlo, pin_mode, ctl_hi, ctl_lo, clr_strobe;
  logic ovp_raw, otp_raw, wdt_evt_raw, cath_gnd_raw;
  logic [LW-1:0] torch_lvl;
  logic [7:0] fault_byte;
  logic irq_oe, drv_off;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  led_fault_guard #(.SYNC_STAGES(2), .HOLD_CYCLES(HOLD), .LVL_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .uvlo(uvlo), .pin_mode(pin_mode),
    .ctl_hi(ctl_hi), .ctl_lo(ctl_lo), .clr_strobe(clr_strobe), .ovp_raw(ovp_raw),
    .otp_raw(otp_raw), .wdt_evt_raw(wdt_evt_raw), .cath_gnd_raw(cath_gnd_raw),
    .torch_lvl(torch_lvl), .fault_byte(fault_byte), .irq_oe(irq_oe), .drv_off(drv_off)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_clear();
    clr_strobe = 1'b1; step(1); clr_strobe = 1'b0;
  endtask

  task automatic t_reset();
    chk(fault_byte, 8'h00, "R1 reset byte");
    chk({7'b0, irq_oe}, 8'h0, "R3 reset irq");
    chk({7'b0, drv_off}, 8'h0, "R3 reset drv_off");
  endtask

  task automatic t_ov_sticky();
    ovp_raw = 1'b1;
    step(2); chk(fault_byte, 8'h00, "R2 not before sync latency");
    step(1); chk(fault_byte, 8'h01, "R1 R2 overvoltage bit0");
    chk({6'b0, drv_off, irq_oe}, 8'h03, "R3 irq and drv_off on fault");
    ovp_raw = 1'b0;
    step(6); chk(fault_byte, 8'h01, "R2 sticky after input drops");
  endtask

  task automatic t_reg_clear();
    step(3); chk(fault_byte, 8'h01, "R4 pins low ignored in register mode");
    reg_clear();
    chk(fault_byte, 8'h00, "R4 strobe clears");
    chk({6'b0, drv_off, irq_oe}, 8'h00, "R3 R4 irq released");
    otp_raw = 1'b1; ovp_raw = 1'b1; step(1); otp_raw = 1'b0; ovp_raw = 1'b0;
    step(3); chk(fault_byte, 8'h05, "R1 overtemp bit2 with bit0");
    reg_clear(); chk(fault_byte, 8'h00, "R4 clear both");
  endtask

  task automatic t_pin_clear();
    pin_mode = 1'b1; ctl_hi = 1'b0; ctl_lo = 1'b1;
    otp_raw = 1'b1; step(1); otp_raw = 1'b0;
    step(3); chk(fault_byte, 8'h04, "R5 fault latched in pin mode");
    reg_clear(); chk(fault_byte, 8'h04, "R5 strobe ignored in pin mode");
    ctl_lo = 1'b0; step(1); chk(fault_byte, 8'h00, "R5 both pins low clears");
    pin_mode = 1'b0;
  endtask

  task automatic t_collide();
    otp_raw = 1'b1; step(1); otp_raw = 1'b0; step(3);
    chk(fault_byte, 8'h04, "R6 precondition");
    ovp_raw = 1'b1; step(2);
    clr_strobe = 1'b1; step(1); clr_strobe = 1'b0;
    chk(fault_byte, 8'h01, "R6 new fault survives same-cycle clear");
    ovp_raw = 1'b0; step(3); reg_clear();
    chk(fault_byte, 8'h00, "R6 cleared afterwards");
  endtask

  task automatic t_disable();
    ovp_raw = 1'b1; step(1); ovp_raw = 1'b0; step(3);
    chk(fault_byte, 8'h01, "R7 precondition");
    chip_en = 1'b0; step(1);
    chk(fault_byte, 8'h00, "R7 enable low wipes");
    chk({7'b0, irq_oe}, 8'h00, "R7 irq released");
    ovp_raw = 1'b1; step(4);
    chk(fault_byte, 8'h00, "R7 faults ignored while disabled");
    ovp_raw = 1'b0; step(3); chip_en = 1'b1; step(2);
    chk(fault_byte, 8'h00, "R7 clean after re-enable");
    otp_raw = 1'b1; step(1); otp_raw = 1'b0; step(3);
    uvlo = 1'b1; step(1);
    chk(fault_byte, 8'h00, "R7 uvlo wipes");
    uvlo = 1'b0; step(1);
  endtask

  task automatic t_sc_hit();
    cath_gnd_raw = 1'b1; step(3);
    torch_lvl = 5'd5;
    step(HOLD); chk(fault_byte, 8'h00, "R8 no short before hold time");
    step(1);    chk(fault_byte, 8'h08, "R8 short-circuit bit3 at hold time");
    torch_lvl = '0; cath_gnd_raw = 1'b0; step(3); reg_clear();
  endtask

  task automatic t_sc_miss();
    torch_lvl = 5'd5;
    step(HOLD + 2); chk(fault_byte, 8'h00, "R8 cathode fine at check");
    cath_gnd_raw = 1'b1;
    step(HOLD); chk(fault_byte, 8'h00, "R8 single check only");
    torch_lvl = '0; cath_gnd_raw = 1'b0; step(3);
  endtask

  task automatic t_sc_restart();
    cath_gnd_raw = 1'b1; step(3);
    torch_lvl = 5'd5; step(HOLD - 10);
    torch_lvl = 5'd9;
    step(HOLD); chk(fault_byte, 8'h00, "R9 level change restarts window");
    step(1);    chk(fault_byte, 8'h08, "R9 check after restarted window");
    reg_clear();
    torch_lvl = '0; step(2);
    torch_lvl = 5'd5; step(HOLD - 10);
    torch_lvl = '0; step(2);
    torch_lvl = 5'd5;
    step(HOLD); chk(fault_byte, 8'h00, "R9 off restarts window");
    step(1);    chk(fault_byte, 8'h08, "R9 check after off-on");
    torch_lvl = '0; cath_gnd_raw = 1'b0; step(3); reg_clear();
  endtask

  task automatic t_flash_wdt();
    pin_mode = 1'b1; ctl_hi = 1'b1; ctl_lo = 1'b1;
    step(HOLD - 1); chk(fault_byte, 8'h00, "R10 no timeout early");
    step(1);        chk(fault_byte, 8'h02, "R10 flash timeout bit1");
    ctl_hi = 1'b0; ctl_lo = 1'b0; step(1);
    chk(fault_byte, 8'h00, "R10 R5 cleared by pins low");
    ctl_hi = 1'b1; ctl_lo = 1'b1; step(HOLD - 5);
    ctl_hi = 1'b0; step(10);
    chk(fault_byte, 8'h00, "R10 short flash no timeout");
    ctl_lo = 1'b0; pin_mode = 1'b0; step(1);
  endtask

  task automatic t_wdt_in();
    wdt_evt_raw = 1'b1; step(1); wdt_evt_raw = 1'b0;
    step(2); chk(fault_byte, 8'h02, "R11 timer event sets bit1");
    reg_clear(); chk(fault_byte, 8'h00, "R11 cleared");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; chip_en = 1'b1; uvlo = 1'b0; pin_mode = 1'b0;
    ctl_hi = 1'b0; ctl_lo = 1'b0; clr_strobe = 1'b0;
    ovp_raw = 1'b0; otp_raw = 1'b0; wdt_evt_raw = 1'b0; cath_gnd_raw = 1'b0;
    torch_lvl = '0;
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_ov_sticky();
    t_reg_clear();
    t_pin_clear();
    t_collide();
    t_disable();
    t_sc_hit();
    t_sc_miss();
    t_sc_restart();
    t_flash_wdt();
    t_wdt_in();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule